// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Sequencer

This block drives the row-by-row refresh of a dot-matrix panel that shows up to two lines of 5x7 characters and two lines of free bitmap symbols. The panel has 60 segment columns and either 16 or 9 common rows. A programmable divider turns the input clock into a slow scan tick, and a slot counter moves one row at a time through the frame. While one row is on the panel, the block reads the twelve cells of the next row from an external display memory. Character cells go through an external font port, and symbol cells are taken as raw dots. The finished 60-bit row is shown at the next slot boundary.

Settings come in as static inputs: the row count, the divider ratio, the line-to-row remap, the character bank used in the 9-row mode, display on/off, a symbols-only mode, a standby request and the character blink style. Each memory entry has a code byte and an attribute byte. For a character cell, attribute bit 0 enables blinking. For a symbol cell, attribute bits 4..0 are per-dot blink enables. The blink phase toggles every 2^(BLINK_W-1) scan ticks, so one full blink period is 2^BLINK_W ticks.

Top module: `lcd_scan_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset, `com` and `seg` are all zero until the first slot boundary, which comes 28 scan ticks later in 16-row mode.
- R2: `div_sel` sets one scan tick to 1, 2, 4 or 8 input clocks (00 gives 1, 11 gives 8). A row slot lasts 28 ticks in 16-row mode, and a frame lasts 448 ticks.
- R3: With `duty9` = 1, a row slot lasts 52 ticks and a frame of 9 rows lasts 468 ticks.
- R4: While the display is shown, `com` is one-hot with bit k for row k (row 1 is bit 0). It steps k to k+1 at each slot boundary and wraps after the last row of the selected mode.
- R5: In 16-row mode, the 0-based row roles are set by `line_sel` as follows. Setting 00: symbol line A on row 0, symbol line B on row 1, character line 1 on rows 2-8, character line 2 on rows 9-15. Setting 01: character line 1 on rows 0-6, character line 2 on rows 7-13, symbol A on row 14, symbol B on row 15. Setting 1x: character line 1 on rows 1-7, character line 2 on rows 8-14, symbol A on row 15, symbol B on row 0.
- R6: In 9-row mode only one character line is shown. It is on rows 2-8, 0-6 or 1-7, and symbol A/B are on rows 0/1, 7/8 or 8/0, for settings 00, 01 and 1x. Its cells come from addresses 0-11 when `bank_sel` = 0 and from addresses 16-27 when `bank_sel` = 1. In 16-row mode, character line 1 uses addresses 0-11 and line 2 uses 16-27.
- R7: Symbol line A uses addresses 32-43 and line B uses 48-59, with no font lookup. Code bit 4..0 of cell n drives `seg[5n]`..`seg[5n+4]`, and code bits 7..5 have no effect.
- R8: Character cell n puts its code and the font row r (0-6, the row's position within its line) on the font port. Font dot bit (4-c) drives `seg[5n+c]`.
- R9: During the active blink phase, a character cell with attribute bit 0 set shows all five dots lit when `blink_style` = 1 and all dark when it is 0. Otherwise it shows its glyph.
- R10: During the active blink phase, a symbol dot whose attribute bit is set is dark. A dot that is not set stays dark in both phases.
- R11: With `disp_on` = 0 or `standby` = 1, `com` and `seg` are all zero. Standby freezes the scan, so the same row returns when it is released.
- R12: With `sym_only` = 1, character rows show all-zero segments and symbol rows are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| duty9 | input | 1 | 1 selects 9-row mode, 0 selects 16-row mode |
| div_sel | input | 2 | Scan tick divider: 2^div_sel clocks per tick |
| line_sel | input | 2 | Row role remap setting |
| bank_sel | input | 1 | Character bank in 9-row mode |
| disp_on | input | 1 | Display enable |
| sym_only | input | 1 | Blank character rows |
| standby | input | 1 | Freeze scan and blank outputs |
| blink_style | input | 1 | 1: blink to all lit, 0: blink to all dark |
| mem_addr | output | 6 | Display memory read address |
| mem_code | input | 8 | Code byte at `mem_addr` (combinational) |
| mem_attr | input | 8 | Attribute byte at `mem_addr` (combinational) |
| font_code | output | 8 | Character code to the font lookup |
| font_row | output | 3 | Glyph row 0-6 to the font lookup |
| font_dots | input | 5 | Glyph row dots, bit 4 is the leftmost column |
| com | output | 16 | One-hot common row select |
| seg | output | 60 | Segment pattern of the current row |

## Verification
A row's segments and its `com` bit change together on the clock edge that ends a slot. That edge comes 28 or 52 scan ticks, each 2^div_sel clocks, after the previous boundary. The content was fetched during the slot before. For this reason, after every settings change the bench lets two boundaries pass before it compares any row. It then samples on the falling edge after each observed `com` change, and it times slots and frames as the exact clock count between those changes. Blink is latched once per fetched row, so each displayed row must equal either its steady or its blinked image, and both images must appear over several frames.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int NCELL      = 12;
    localparam int CELL_DOTS  = 5;
    localparam int NSEG       = NCELL * CELL_DOTS;
    localparam int ROWS_FULL  = 16;
    localparam int ROWS_SHORT = 9;
    localparam int GLYPH_H    = 7;
    localparam int ROW_W      = $clog2(ROWS_FULL);
    localparam int ADDR_W     = 6;
    localparam int CODE_W     = 8;
    localparam int FROW_W     = $clog2(GLYPH_H + 1);

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CHAR1,
        RK_CHAR2,
        RK_SYMA,
        RK_SYMB
    } row_kind_e;

    typedef struct packed {
        row_kind_e           kind;
        logic [FROW_W-1:0]   frow;
    } row_role_t;

    // Role of a common row for the selected mode and remap setting.
    function automatic row_role_t decode_row(input logic duty9,
                                             input logic [1:0] lsel,
                                             input logic [ROW_W-1:0] row);
        row_role_t res;
        int first, sym_a, sym_b, ri;
        ri = int'(row);
        if (lsel == 2'b00) begin
            first = 2; sym_a = 0; sym_b = 1;
        end else if (lsel == 2'b01) begin
            first = 0;
            sym_a = duty9 ? ROWS_SHORT - 2 : ROWS_FULL - 2;
            sym_b = duty9 ? ROWS_SHORT - 1 : ROWS_FULL - 1;
        end else begin
            first = 1;
            sym_a = duty9 ? ROWS_SHORT - 1 : ROWS_FULL - 1;
            sym_b = 0;
        end
        res.kind = RK_NONE;
        res.frow = '0;
        if (ri == sym_a) begin
            res.kind = RK_SYMA;
        end else if (ri == sym_b) begin
            res.kind = RK_SYMB;
        end else if (ri >= first && ri < first + GLYPH_H) begin
            res.kind = RK_CHAR1;
            res.frow = FROW_W'(ri - first);
        end else if (!duty9 && ri >= first + GLYPH_H && ri < first + 2 * GLYPH_H) begin
            res.kind = RK_CHAR2;
            res.frow = FROW_W'(ri - first - GLYPH_H);
        end
        return res;
    endfunction

    // First memory address of the cells that feed a row kind.
    function automatic logic [ADDR_W-1:0] cell_base(input row_kind_e kind,
                                                    input logic duty9,
                                                    input logic bank);
        logic [ADDR_W-1:0] b;
        case (kind)
            RK_CHAR1: b = (duty9 && bank) ? ADDR_W'(16) : ADDR_W'(0);
            RK_CHAR2: b = ADDR_W'(16);
            RK_SYMA:  b = ADDR_W'(32);
            RK_SYMB:  b = ADDR_W'(48);
            default:  b = '0;
        endcase
        return b;
    endfunction

    function automatic logic [CELL_DOTS-1:0] flip_dots(input logic [CELL_DOTS-1:0] d);
        logic [CELL_DOTS-1:0] o;
        for (int i = 0; i < CELL_DOTS; i++) o[i] = d[CELL_DOTS-1-i];
        return o;
    endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int SLOT_FULL  = 28,
    parameter int SLOT_SHORT = 52,
    parameter int BLINK_W    = 15,
    parameter int DIV_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  logic             duty9,
    input  logic [DIV_W-1:0] div_sel,
    output logic             boundary,
    output logic [ROW_W-1:0] nxt_row,
    output logic             blink_ph
);

    localparam int DCNT_W   = (2 ** DIV_W) - 1;
    localparam int SLOT_MAX = (SLOT_FULL > SLOT_SHORT) ? SLOT_FULL : SLOT_SHORT;
    localparam int SLOT_W   = $clog2(SLOT_MAX + 1);

    logic [DCNT_W-1:0]  div_cnt;
    logic [DCNT_W-1:0]  div_mask;
    logic               tick;
    logic [SLOT_W-1:0]  slot_cnt;
    logic [SLOT_W-1:0]  slot_end;
    logic [ROW_W-1:0]   row_end;
    logic [BLINK_W-1:0] blink_cnt;

    always_comb begin
        div_mask = DCNT_W'((1 << div_sel) - 1);
        tick     = !standby && ((div_cnt & div_mask) == div_mask);
        slot_end = duty9 ? SLOT_W'(SLOT_SHORT - 1) : SLOT_W'(SLOT_FULL - 1);
        row_end  = duty9 ? ROW_W'(ROWS_SHORT - 1) : ROW_W'(ROWS_FULL - 1);
        boundary = tick && (slot_cnt >= slot_end);
        blink_ph = blink_cnt[BLINK_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt   <= '0;
            slot_cnt  <= '0;
            nxt_row   <= '0;
            blink_cnt <= '0;
        end else begin
            if (!standby) div_cnt <= div_cnt + 1'b1;
            if (tick) begin
                slot_cnt  <= boundary ? '0 : slot_cnt + 1'b1;
                blink_cnt <= blink_cnt + 1'b1;
            end
            if (boundary) nxt_row <= (nxt_row >= row_end) ? '0 : nxt_row + 1'b1;
        end
    end

    // R3
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        slot_cnt < SLOT_W'(SLOT_MAX));

    // R4
    row_range_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && duty9) |=> (nxt_row < ROW_W'(ROWS_SHORT)));

endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch
    import lcd_scan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic [ROW_W-1:0]     row,
    input  logic                 duty9,
    input  logic [1:0]           lsel,
    input  logic                 bank,
    input  logic                 sym_only,
    input  logic                 blink_style,
    input  logic                 blink_ph,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [CODE_W-1:0]    mem_code,
    input  logic [CODE_W-1:0]    mem_attr,
    output logic [CODE_W-1:0]    font_code,
    output logic [FROW_W-1:0]    font_row,
    input  logic [CELL_DOTS-1:0] font_dots,
    output logic [NSEG-1:0]      pattern
);

    localparam int IDX_W = $clog2(NCELL + 1);

    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     idx_c;
    logic                 busy;
    logic                 ph_q;
    logic [NSEG-1:0]      shadow;
    row_role_t            role;
    logic [CELL_DOTS-1:0] cell_dots;

    always_comb begin
        role      = decode_row(duty9, lsel, row);
        busy      = (idx < IDX_W'(NCELL));
        idx_c     = busy ? idx : '0;
        mem_addr  = cell_base(role.kind, duty9, bank) + ADDR_W'(idx_c);
        font_code = mem_code;
        font_row  = role.frow;
        case (role.kind)
            RK_SYMA, RK_SYMB:
                cell_dots = mem_code[CELL_DOTS-1:0] & ~(mem_attr[CELL_DOTS-1:0] & {CELL_DOTS{ph_q}});
            RK_CHAR1, RK_CHAR2:
                if (sym_only)                cell_dots = '0;
                else if (mem_attr[0] && ph_q) cell_dots = {CELL_DOTS{blink_style}};
                else                          cell_dots = font_dots;
            default:
                cell_dots = '0;
        endcase
        pattern = shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            ph_q   <= 1'b0;
            shadow <= '0;
        end else if (restart) begin
            idx  <= '0;
            ph_q <= blink_ph;
        end else if (busy) begin
            shadow[int'(idx_c) * CELL_DOTS +: CELL_DOTS] <= flip_dots(cell_dots);
            idx <= idx + 1'b1;
        end
    end

    // R8
    fetch_done_chk: assert property (@(posedge clk) disable iff (rst)
        restart |-> !busy);

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int SLOT_FULL  = 28,
    parameter int SLOT_SHORT = 52,
    parameter int BLINK_W    = 15,
    parameter int DIV_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 duty9,
    input  logic [DIV_W-1:0]     div_sel,
    input  logic [1:0]           line_sel,
    input  logic                 bank_sel,
    input  logic                 disp_on,
    input  logic                 sym_only,
    input  logic                 standby,
    input  logic                 blink_style,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [CODE_W-1:0]    mem_code,
    input  logic [CODE_W-1:0]    mem_attr,
    output logic [CODE_W-1:0]    font_code,
    output logic [FROW_W-1:0]    font_row,
    input  logic [CELL_DOTS-1:0] font_dots,
    output logic [ROWS_FULL-1:0] com,
    output logic [NSEG-1:0]      seg
);

    logic             boundary;
    logic [ROW_W-1:0] nxt_row;
    logic             blink_ph;
    logic [NSEG-1:0]  pattern;
    logic [ROWS_FULL-1:0] com_q;
    logic [NSEG-1:0]  seg_q;
    logic             shown;

    lcd_scan_timing #(
        .SLOT_FULL (SLOT_FULL),
        .SLOT_SHORT(SLOT_SHORT),
        .BLINK_W   (BLINK_W),
        .DIV_W     (DIV_W)
    ) u_timing (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .duty9   (duty9),
        .div_sel (div_sel),
        .boundary(boundary),
        .nxt_row (nxt_row),
        .blink_ph(blink_ph)
    );

    lcd_row_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .restart    (boundary),
        .row        (nxt_row),
        .duty9      (duty9),
        .lsel       (line_sel),
        .bank       (bank_sel),
        .sym_only   (sym_only),
        .blink_style(blink_style),
        .blink_ph   (blink_ph),
        .mem_addr   (mem_addr),
        .mem_code   (mem_code),
        .mem_attr   (mem_attr),
        .font_code  (font_code),
        .font_row   (font_row),
        .font_dots  (font_dots),
        .pattern    (pattern)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            com_q <= '0;
            seg_q <= '0;
        end else if (boundary) begin
            com_q          <= '0;
            com_q[nxt_row] <= 1'b1;
            seg_q          <= pattern;
        end
    end

    always_comb begin
        shown = disp_on && !standby;
        com   = shown ? com_q : '0;
        seg   = shown ? seg_q : '0;
    end

    // R4
    com_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com));

    // R4
    com_step_chk: assert property (@(posedge clk) disable iff (rst)
        boundary |=> $onehot(com_q));

    // R11
    standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> $stable(com_q));

endmodule

// File: tb/lcd_scan_seq_bench.sv
module lcd_scan_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        duty9 = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic [1:0]  line_sel = 2'd0;
    logic        bank_sel = 1'b0;
    logic        disp_on = 1'b1;
    logic        sym_only = 1'b0;
    logic        standby = 1'b0;
    logic        blink_style = 1'b1;
    logic [5:0]  mem_addr;
    logic [7:0]  mem_code, mem_attr, font_code;
    logic [2:0]  font_row;
    logic [4:0]  font_dots;
    logic [15:0] com;
    logic [59:0] seg;

    logic [7:0]  mcode [64];
    logic [7:0]  mattr [64];

    int     nvec = 0;
    int     nbad = 0;
    longint cyc  = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] fnt(input logic [7:0] c, input logic [2:0] r);
        return 5'(int'(c) * 7 + int'(r) * 11) ^ 5'(c >> 3);
    endfunction

    assign mem_code  = mcode[mem_addr];
    assign mem_attr  = mattr[mem_addr];
    assign font_dots = fnt(font_code, font_row);

    lcd_scan_seq #(.BLINK_W(8)) u_lcd_scan_seq (
        .clk(clk), .rst(rst), .duty9(duty9), .div_sel(div_sel),
        .line_sel(line_sel), .bank_sel(bank_sel), .disp_on(disp_on),
        .sym_only(sym_only), .standby(standby), .blink_style(blink_style),
        .mem_addr(mem_addr), .mem_code(mem_code), .mem_attr(mem_attr),
        .font_code(font_code), .font_row(font_row), .font_dots(font_dots),
        .com(com), .seg(seg)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Row role per R5/R6: 0 none, 1 char line 1, 2 char line 2, 3 symbol A, 4 symbol B
    function automatic int role_of(input int r, output int fr);
        int sa, sb, c1;
        case (line_sel)
            2'd0:    begin sa = 0; sb = 1; c1 = 2; end
            2'd1:    begin sa = duty9 ? 7 : 14; sb = sa + 1; c1 = 0; end
            default: begin sa = duty9 ? 8 : 15; sb = 0; c1 = 1; end
        endcase
        fr = 0;
        if (r == sa) return 3;
        if (r == sb) return 4;
        if (r >= c1 && r < c1 + 7) begin fr = r - c1; return 1; end
        if (!duty9 && r >= c1 + 7 && r < c1 + 14) begin fr = r - c1 - 7; return 2; end
        return 0;
    endfunction

    function automatic logic [59:0] exp_seg(input int r, input bit ph);
        int fr, k, base, a;
        logic [4:0] d;
        logic [59:0] s;
        s = '0;
        k = role_of(r, fr);
        base = (k == 1) ? ((duty9 && bank_sel) ? 16 : 0) : (k == 2) ? 16 : (k == 3) ? 32 : 48;
        for (int n = 0; n < 12; n++) begin
            a = base + n;
            case (k)
                1, 2:    d = sym_only ? 5'd0 : (mattr[a][0] && ph) ? {5{blink_style}} : fnt(mcode[a], 3'(fr));
                3, 4:    d = mcode[a][4:0] & ~(mattr[a][4:0] & {5{ph}});
                default: d = 5'd0;
            endcase
            for (int c = 0; c < 5; c++) s[5 * n + c] = d[4 - c];
        end
        return s;
    endfunction

    task automatic wait_change(output int r);
        logic [15:0] p;
        p = com;
        do @(negedge clk); while (com == p);
        r = -1;
        for (int i = 0; i < 16; i++) if (com[i]) r = i;
    endtask

    task automatic scan_check(input string req, input int nrows, output bit saw0, output bit saw1);
        int r, prev, rows, nx;
        logic [59:0] e0, e1;
        rows = duty9 ? 9 : 16;
        saw0 = 0; saw1 = 0;
        wait_change(r);
        wait_change(r);
        prev = r;
        repeat (nrows) begin
            wait_change(r);
            nx = (prev + 1) % rows;
            check(com == (16'd1 << nx), "R4 row order", 64'(com), 64'(16'd1 << nx));
            e0 = exp_seg(r, 1'b0);
            e1 = exp_seg(r, 1'b1);
            if (seg == e0) begin
                if (e0 != e1) saw0 = 1;
            end else if (seg == e1) begin
                saw1 = 1;
            end
            check(seg == e0 || seg == e1, req, 64'(seg), 64'(e0));
            prev = r;
        end
    endtask

    task automatic slot_timing(input int dsel, input bit d9);
        int r, div, slot, rows;
        longint t0;
        div_sel = 2'(dsel); duty9 = d9;
        div  = 1 << dsel;
        slot = d9 ? 52 : 28;
        rows = d9 ? 9 : 16;
        wait_change(r); wait_change(r);
        t0 = cyc;
        wait_change(r);
        check(cyc - t0 == longint'(slot * div), d9 ? "R3 slot" : "R2 slot", 64'(cyc - t0), 64'(slot * div));
        t0 = cyc;
        repeat (rows) wait_change(r);
        check(cyc - t0 == longint'((d9 ? 468 : 448) * div), d9 ? "R3 frame" : "R2 frame",
              64'(cyc - t0), 64'((d9 ? 468 : 448) * div));
    endtask

    task automatic fill_mem(input bit zero_attr);
        for (int a = 0; a < 64; a++) begin
            mcode[a] = 8'($urandom);
            mattr[a] = zero_attr ? 8'd0 : 8'($urandom);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog (all R) act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        bit s0, s1;
        int r;
        logic [15:0] com_b;
        void'($urandom(32'd2024));
        fill_mem(1'b1);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(com == 0 && seg == 0, "R1 reset com/seg", 64'(com), 64'd0);
        repeat (15) @(negedge clk);
        check(com == 0 && seg == 0, "R1 before first boundary", 64'(com), 64'd0);

        // R2 divider ratios, R3 short mode timing
        for (int d = 0; d < 4; d++) slot_timing(d, 1'b0);
        slot_timing(0, 1'b1);
        slot_timing(2, 1'b1);
        div_sel = 2'd0;

        // R5 remap in 16-row mode
        duty9 = 1'b0;
        for (int l = 0; l < 4; l++) begin
            line_sel = 2'(l);
            scan_check("R5/R7/R8 16-row map", 16, s0, s1);
        end

        // R6 9-row mapping with both banks
        duty9 = 1'b1;
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < 3; l++) begin
                bank_sel = b[0];
                line_sel = 2'(l);
                scan_check("R6 9-row map/bank", 9, s0, s1);
            end
        end

        // R7 upper code bits on symbol cells have no effect
        for (int a = 32; a < 64; a++) mcode[a] = 8'hE0;
        duty9 = 1'b0; line_sel = 2'd0;
        scan_check("R7 sym upper bits", 16, s0, s1);
        fill_mem(1'b1);

        // R12 symbols-only
        sym_only = 1'b1;
        scan_check("R12 symbols only", 16, s0, s1);
        duty9 = 1'b1;
        scan_check("R12 symbols only 9-row", 9, s0, s1);
        sym_only = 1'b0;

        // random settings and contents
        for (int it = 0; it < 16; it++) begin
            fill_mem(1'b1);
            duty9 = 1'($urandom); line_sel = 2'($urandom); bank_sel = 1'($urandom);
            sym_only = ($urandom % 4) == 0; div_sel = 2'($urandom % 2);
            scan_check("R5/R6/R7/R8/R12 random", duty9 ? 9 : 16, s0, s1);
        end
        div_sel = 2'd0; sym_only = 1'b0; duty9 = 1'b0; line_sel = 2'd0;

        // R9 character blink, both styles
        for (int st = 0; st < 2; st++) begin
            fill_mem(1'b1);
            for (int a = 0; a < 28; a++) mattr[a] = 8'h01;
            blink_style = st[0];
            scan_check("R9 char blink", 128, s0, s1);
            check(s0 && s1, "R9 both phases seen", 64'({s0, s1}), 64'd3);
        end

        // R10 symbol dot blink
        fill_mem(1'b1);
        for (int a = 32; a < 64; a++) begin
            mcode[a] = 8'($urandom) | 8'h01;
            mattr[a] = 8'h1F;
        end
        scan_check("R10 symbol blink", 128, s0, s1);
        check(s0 && s1, "R10 both phases seen", 64'({s0, s1}), 64'd3);
        fill_mem(1'b1);

        // R11 display off
        disp_on = 1'b0;
        repeat (3) begin
            repeat (97) @(negedge clk);
            check(com == 0 && seg == 0, "R11 display off", 64'(com), 64'd0);
        end
        disp_on = 1'b1;

        // R11 standby blanks and freezes the scan
        wait_change(r);
        repeat (5) @(negedge clk);
        com_b = com;
        standby = 1'b1;
        repeat (300) @(negedge clk);
        check(com == 0 && seg == 0, "R11 standby dark", 64'(com), 64'd0);
        standby = 1'b0;
        @(negedge clk);
        check(com == com_b, "R11 standby resume row", 64'(com), 64'(com_b));

        summary();
        $finish;
    end

endmodule